// File: doc/BRIEF.md
# Duty-Cycle Noise Switching Generator

This block drives the calibration-noise switch of a receiver front end with a single-bit waveform. A free-running prescaler divides the 1 MHz reference into a 4 ms base tick. A power-of-two divider stretches that tick into a step of 4, 8, 16 or 32 ms. A four-step phase counter then shapes the output so that it is high for none, one, two or all four steps of each cycle. Because its timing chain is private, the noise rate can be changed without disturbing any other switching generator on the same clock.

Settings for duty and rate are sampled only at a step boundary. A change on the control inputs therefore never shortens or splits a step, and the output only toggles at step boundaries. A separate front-end controller power bit goes straight through the block to its own output.

Top module: `noise_pattern_gen`

## Requirements
- R1: While rst_ni is low, and until the first step boundary after reset, noise_o is 0.
- R2: With duty code duty_sel_i = 2'b00 (off), noise_o stays 0.
- R3: With duty code 2'b01 (25 %), noise_o is high for one step and then low for three steps, repeating.
- R4: With duty code 2'b10 (50 %), noise_o is high for two consecutive steps and then low for two steps, repeating.
- R5: With duty code 2'b11 (100 %), noise_o stays 1 once the code has been taken in.
- R6: With rate code n on rate_sel_i (0..3), a step lasts PRESCALE * 2^n clock cycles. With the defaults this is 4, 8, 16 or 32 ms on a 1 MHz clock.
- R7: A new duty code takes effect only at the next step boundary, so the step in progress keeps its level for its full length.
- R8: A new rate code takes effect only at the next step boundary, so the step in progress keeps its old length.
- R9: fe_on_o equals fe_on_i in the same cycle.
- R10: The prescaler emits a base tick exactly once every PRESCALE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 1 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| duty_sel_i | input | 2 | Duty code: 00 off, 01 25 %, 10 50 %, 11 100 % |
| rate_sel_i | input | 2 | Step period exponent n; step = 4 ms * 2^n |
| fe_on_i | input | 1 | Front-end controller power request |
| noise_o | output | 1 | Noise switching waveform |
| fe_on_o | output | 1 | Front-end controller power, passed through |

## Verification
If the prescaler or the divider holds the wrong count, the error shows up as an output run whose length is not the expected multiple of PRESCALE. It becomes visible at the first toggle, which is at most one full four-step cycle later. If the phase counter or a latched setting is wrong, the high and low run lengths come out swapped or unequal within the same cycle. A latch that takes in settings outside a boundary appears as a run that ends early, directly after the control inputs change.

// File: rtl/noise_gen_pkg.sv
package noise_gen_pkg;

  typedef enum logic [1:0] {
    DUTY_OFF  = 2'b00,
    DUTY_QTR  = 2'b01,
    DUTY_HALF = 2'b10,
    DUTY_FULL = 2'b11
  } duty_e;

  localparam int unsigned PHASES = 4;
  localparam int unsigned PH_W   = $clog2(PHASES);

  // output level for a given duty code while in phase ph
  function automatic logic duty_level(duty_e d, logic [PH_W-1:0] ph);
    logic lvl;
    unique case (d)
      DUTY_OFF:  lvl = 1'b0;
      DUTY_QTR:  lvl = (ph == '0);
      DUTY_HALF: lvl = (ph < PH_W'(PHASES / 2));
      DUTY_FULL: lvl = 1'b1;
      default:   lvl = 1'b0;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/noise_prescaler.sv
module noise_prescaler #(
  parameter int unsigned PRESCALE = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_PRE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST) else $error("prescaler out of range"); // R10
  AST_PRE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0)) else $error("prescaler did not wrap"); // R10

endmodule

// File: rtl/noise_rate_div.sv
module noise_rate_div #(
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              step_o
);
  localparam int unsigned DIV_W = (1 << RATE_W) - 1;

  logic [RATE_W-1:0] rate_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [DIV_W:0]    span;
  logic [DIV_W-1:0]  last;

  assign span   = (DIV_W + 1)'(1) << rate_q;
  assign last   = DIV_W'(span - 1'b1);
  assign step_o = tick_i && (cnt_q == last);

  // rate is taken in only on a step boundary; counter restarts there too
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      cnt_q  <= '0;
    end else if (step_o) begin
      rate_q <= rate_i;
      cnt_q  <= '0;
    end else if (tick_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last) else $error("divider beyond span"); // R6
  AST_RATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_o |=> $stable(rate_q)) else $error("rate changed mid-step"); // R8

endmodule

// File: rtl/noise_shaper.sv
module noise_shaper
  import noise_gen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic [1:0] duty_i,
  output logic       noise_o
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_nxt;
  duty_e           duty_q;
  logic            noise_q;

  assign phase_nxt = phase_q + 1'b1;
  assign noise_o   = noise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      duty_q  <= DUTY_OFF;
      noise_q <= 1'b0;
    end else if (step_i) begin
      phase_q <= phase_nxt;
      duty_q  <= duty_e'(duty_i);
      noise_q <= duty_level(duty_e'(duty_i), phase_nxt);
    end
  end

  AST_DUTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(duty_q)) else $error("duty changed mid-step"); // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(noise_q)) else $error("output toggled mid-step"); // R7
  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q == DUTY_OFF) |-> !noise_q) else $error("high while off"); // R2
  AST_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q == DUTY_FULL) |-> noise_q) else $error("low while full"); // R5
  AST_QTR_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q == DUTY_QTR && noise_q) |-> (phase_q == '0)) else $error("quarter misplaced"); // R3

endmodule

// File: rtl/noise_pattern_gen.sv
module noise_pattern_gen #(
  parameter int unsigned PRESCALE = 4000,
  parameter int unsigned RATE_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        duty_sel_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              fe_on_i,
  output logic              noise_o,
  output logic              fe_on_o
);
  logic base_tick;
  logic step_tick;

  noise_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (base_tick)
  );

  noise_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (base_tick),
    .rate_i (rate_sel_i),
    .step_o (step_tick)
  );

  noise_shaper u_shape (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step_tick),
    .duty_i  (duty_sel_i),
    .noise_o (noise_o)
  );

  assign fe_on_o = fe_on_i;

  AST_STEP_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_tick |-> base_tick) else $error("step without base tick"); // R6

endmodule

// File: tb/noise_pattern_gen_test.sv
`timescale 1ns/1ps
module noise_pattern_gen_test;
  localparam int P = 8;
  localparam int LIM = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] duty = 2'b00;
  logic [1:0] rate = 2'b00;
  logic fe_on = 1'b0;
  logic noise, fe_out;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  noise_pattern_gen #(.PRESCALE(P), .RATE_W(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .duty_sel_i(duty), .rate_sel_i(rate),
    .fe_on_i(fe_on), .noise_o(noise), .fe_on_o(fe_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_level(input logic lvl);
    int g = 0;
    while (noise !== lvl && g < LIM) begin g++; @(negedge clk); end
  endtask

  task automatic measure_run(input logic lvl, output int len);
    len = 0;
    while (noise === lvl && len < LIM) begin len++; @(negedge clk); end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(noise === 1'b0, "R1 in reset", noise, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(noise === 1'b0, "R1 after release", noise, 0);
  endtask

  task automatic t_fe_pass;
    @(negedge clk); fe_on = 1'b1; #1;
    check(fe_out === 1'b1, "R9 on", fe_out, 1);
    @(negedge clk); fe_on = 1'b0; #1;
    check(fe_out === 1'b0, "R9 off", fe_out, 0);
  endtask

  task automatic t_off;
    int highs = 0;
    duty = 2'b00;
    repeat (P * 8 + 2) @(negedge clk);
    for (int i = 0; i < 512; i++) begin
      if (noise !== 1'b0) highs++;
      @(negedge clk);
    end
    check(highs == 0, "R2 off stays low", highs, 0);
  endtask

  task automatic t_quarter(input logic [1:0] n);
    int h, l;
    duty = 2'b01; rate = n;
    wait_level(1); wait_level(0); wait_level(1);
    measure_run(1, h); measure_run(0, l);
    check(h == (P << n), "R3/R6 quarter high", h, P << n);
    check(l == 3 * (P << n), "R3/R6 quarter low", l, 3 * (P << n));
  endtask

  task automatic t_half(input logic [1:0] n);
    int h, l;
    duty = 2'b10; rate = n;
    wait_level(1); wait_level(0); wait_level(1);
    measure_run(1, h); measure_run(0, l);
    check(h == 2 * (P << n), "R4/R6 half high", h, 2 * (P << n));
    check(l == 2 * (P << n), "R4/R6 half low", l, 2 * (P << n));
  endtask

  task automatic t_full;
    int lows = 0;
    duty = 2'b11; rate = 2'b01;
    wait_level(1);
    repeat (P * 2 + 2) @(negedge clk);
    for (int i = 0; i < 8 * P * 4; i++) begin
      if (noise !== 1'b1) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R5 full stays high", lows, 0);
  endtask

  // rate change right after a rising boundary: current step keeps old length
  task automatic t_rate_change;
    int h, l;
    duty = 2'b10; rate = 2'b00;
    wait_level(0); wait_level(1); wait_level(0); wait_level(1);
    rate = 2'b11;
    measure_run(1, h); measure_run(0, l);
    check(h == P + 8 * P, "R8 high across rate change", h, 9 * P);
    check(l == 16 * P, "R8 low at new rate", l, 16 * P);
  endtask

  // duty change right after a falling boundary: low step completes
  task automatic t_duty_change;
    int h, l;
    int lows = 0;
    duty = 2'b01; rate = 2'b00;
    wait_level(0); wait_level(1); wait_level(0); wait_level(1);
    measure_run(1, h);
    duty = 2'b11;
    measure_run(0, l);
    check(l == P, "R7 low step completes", l, P);
    for (int i = 0; i < 4 * P; i++) begin
      if (noise !== 1'b1) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R7 new duty after boundary", lows, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fe_pass();
    t_off();
    for (int n = 0; n < 4; n++) t_quarter(2'(n));
    t_half(2'b00);
    t_half(2'b10);
    t_full();
    t_rate_change();
    t_duty_change();
    t_off();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule